// File: doc/BRIEF.md
# Display Line Packet Sequencer

This block decides, for every display line, which link packets go out and in what order, and how many payload bytes each one carries. A twelve-word sequence table holds one pair of words per line kind (six kinds). Each word holds three packet slots, so a line can carry up to six packets. Every slot has an enable bit, a 6-bit data type and a 3-bit selector into an eight-entry length table. The length table is not programmed directly. The block derives it from the horizontal timing in pixels, the pixel format and the operating mode, so the byte counts always agree with the timing.

A line begins with a one-cycle `line_start` pulse that carries the line kind. The sequencer copies the selected word pair and the derived length table into registers, then waits out a start-of-line delay of eight pixels expressed in bytes. It then presents the enabled slots one at a time on a valid/ready interface to the downstream packet builder. After the last slot it raises `line_done` for one cycle. If the low word of the pair asked for it, it also raises `lp_req` in that same cycle, to return the link to low power. In command mode it also supplies the memory-write opcode that belongs to the line.

Top module: `dsi_line_sequencer`

## Requirements
- R1: Straight after reset, `pkt_valid`, `line_done`, `lp_req` and `line_busy` are all 0.
- R2: The start-of-line delay is 8 pixels converted to bytes: 24 cycles for format 0 (24-bit) and format 1 (packed 18-bit), 16 cycles for format 2 (16-bit) and 18 cycles for format 3 (loose 18-bit). `pkt_valid` first rises exactly that many clock edges after the edge that samples `line_start`. A line with no enabled slot raises `line_done` at that same point and presents no packet.
- R3: Word 2p of the table is the low word and word 2p+1 is the high word of line kind p. Within a word, slot k (k = 0, 1, 2) has its length selector at bits 10k+2..10k, its data type at bits 10k+8..10k+3 and its enable at bit 10k+9. Slots are presented in the order low slot 0, 1, 2, then high slot 0, 1, 2, and disabled slots are skipped.
- R4: Pixel-to-byte conversion multiplies by 3 for formats 0 and 1, by 2 for format 2, and by 9/4 (rounded down) for format 3. In video modes the length entries are: 0 → 0, 1 → sync bytes − 10, 2 → back-porch bytes − 14, 3 → active bytes, 4 → front-porch bytes − 8, 5 → 0, 6 → 15, 7 → 15.
- R5: In video-with-sync-events mode (mode 1), the back-porch entry also includes the sync bytes (sync bytes + back-porch bytes − 14). In video-with-sync-pulses mode (modes 2 and 3), it does not. In both video modes `pkt_dcs` is 0x00.
- R6: In command mode (mode 0), length entries 3 and 5 both equal 1 + active bytes, and all other entries are 0. `pkt_dcs` is 0x2C when `first_line` was high at `line_start`, and 0x3C otherwise.
- R7: While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid`, `pkt_dt` and `pkt_len` hold steady. Each handshake moves to the next enabled slot.
- R8: `line_done` is a single-cycle pulse. It is raised on the clock edge that accepts the last enabled packet. `lp_req` equals bit 30 of the line's low word in that cycle and is 0 at all other times.
- R9: A `line_start` is ignored while `line_busy` is high, or when `line_type` is 6 or 7.
- R10: The table pair and the length table are captured at `line_start`. A table write in the same cycle as `line_start`, or during the line, affects only later lines.
- R11: The subtractions in the length entries saturate at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_we | input | 1 | Sequence-table write strobe |
| tbl_addr | input | 4 | Table word index 0..11; other values are ignored |
| tbl_wdata | input | 32 | Table word data |
| pix_fmt | input | 2 | Pixel format 0..3 (see R2, R4) |
| seq_mode | input | 2 | 0 command, 1 video with sync events, 2/3 video with sync pulses |
| hsync_px | input | 16 | Horizontal sync width in pixels |
| hback_px | input | 16 | Horizontal back porch in pixels |
| hact_px | input | 16 | Active pixels per line |
| hfront_px | input | 16 | Horizontal front porch in pixels |
| line_start | input | 1 | One-cycle request to sequence a line |
| line_type | input | 3 | Line kind 0..5, selects the table pair |
| first_line | input | 1 | Marks the first line of a frame (command opcode) |
| pkt_ready | input | 1 | Downstream accepts the presented packet |
| pkt_valid | output | 1 | A packet descriptor is presented |
| pkt_dt | output | 6 | Packet data type |
| pkt_len | output | 16 | Packet payload length in bytes |
| pkt_dcs | output | 8 | Memory-write opcode for command mode, else 0 |
| line_done | output | 1 | One-cycle end-of-line pulse |
| lp_req | output | 1 | Low-power request, only with `line_done` |
| line_busy | output | 1 | A line is being sequenced |

## Verification
Two events can fall in the same cycle: a table write to the pair being started, and the `line_start` that captures that pair. The bench raises `tbl_we` and `line_start` on the same clock edge and checks that the line it starts still shows the old slots. It then checks that the next line shows the new slots. A second overlap is a fresh `line_start` that arrives while a line is still running. The bench judges it at the ports: the count of packets, the count of `line_done` pulses, and `line_busy` staying low after the line ends.

// File: rtl/dsi_seq_pkg.sv
package dsi_seq_pkg;

    localparam int PX_W        = 16;
    localparam int LEN_W       = 16;
    localparam int WORD_W      = 32;
    localparam int DT_W        = 6;
    localparam int SEL_W       = 3;
    localparam int SLOTS_PER_W = 3;
    localparam int SLOTS       = 2 * SLOTS_PER_W;
    localparam int PAIRS       = 6;
    localparam int TBL_WORDS   = 2 * PAIRS;
    localparam int LEN_ENTRIES = 1 << SEL_W;
    localparam int SLOT_STRIDE = 10;
    localparam int DT_LSB      = 3;
    localparam int EN_LSB      = 9;
    localparam int LP_BIT      = 30;
    localparam int IDX_W       = $clog2(SLOTS + 1);

    localparam logic [7:0] DCS_MEM_START = 8'h2C;
    localparam logic [7:0] DCS_MEM_CONT  = 8'h3C;

    typedef enum logic [1:0] {
        FMT_RGB24       = 2'd0,
        FMT_RGB18_PK    = 2'd1,
        FMT_RGB16       = 2'd2,
        FMT_RGB18_LOOSE = 2'd3
    } pix_fmt_e;

    typedef enum logic [1:0] {
        MODE_CMD       = 2'd0,
        MODE_VID_EVT   = 2'd1,
        MODE_VID_PULSE = 2'd2,
        MODE_VID_ALT   = 2'd3
    } seq_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SOL  = 2'd1,
        ST_EMIT = 2'd2,
        ST_DONE = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic             en;
        logic [DT_W-1:0]  dt;
        logic [SEL_W-1:0] sel;
    } slot_t;

    typedef logic [LEN_ENTRIES-1:0][LEN_W-1:0] len_tbl_t;

    function automatic logic [LEN_W-1:0] px_to_bytes(input logic [PX_W-1:0] px,
                                                     input pix_fmt_e f);
        logic [PX_W+3:0] w;
        logic [PX_W+3:0] t;
        w = {4'b0, px};
        case (f)
            FMT_RGB16:       t = w << 1;
            FMT_RGB18_LOOSE: t = ((w << 3) + w) >> 2;
            default:         t = (w << 1) + w;
        endcase
        return t[LEN_W-1:0];
    endfunction

    function automatic logic [LEN_W-1:0] sat_sub(input logic [LEN_W-1:0] a,
                                                 input logic [LEN_W-1:0] b);
        return (a > b) ? (a - b) : '0;
    endfunction

    // Returns {hit, index} of the first set mask bit at or after 'from'.
    function automatic logic [IDX_W:0] find_slot(input logic [SLOTS-1:0] mask,
                                                 input logic [IDX_W-1:0] from);
        logic             hit;
        logic [IDX_W-1:0] idx;
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!hit && mask[i] && (IDX_W'(i) >= from)) begin
                hit = 1'b1;
                idx = IDX_W'(i);
            end
        end
        return {hit, idx};
    endfunction

endpackage

// File: rtl/dsi_seq_table.sv
module dsi_seq_table
    import dsi_seq_pkg::*;
#(
    parameter int WORDS  = TBL_WORDS,
    parameter int DATA_W = WORD_W,
    localparam int AW    = $clog2(WORDS),
    localparam int PW    = $clog2(WORDS / 2 + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PW-1:0]     pair,
    output logic [DATA_W-1:0] lo_word,
    output logic [DATA_W-1:0] hi_word
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (we && (int'(waddr) < WORDS)) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb begin
        lo_word = '0;
        hi_word = '0;
        for (int p = 0; p < WORDS / 2; p++) begin
            if (int'(pair) == p) begin
                lo_word = mem[2*p];
                hi_word = mem[2*p+1];
            end
        end
    end

endmodule

// File: rtl/dsi_len_calc.sv
module dsi_len_calc
    import dsi_seq_pkg::*;
(
    input  pix_fmt_e         fmt,
    input  seq_mode_e        mode,
    input  logic [PX_W-1:0]  hsync_px,
    input  logic [PX_W-1:0]  hback_px,
    input  logic [PX_W-1:0]  hact_px,
    input  logic [PX_W-1:0]  hfront_px,
    output len_tbl_t         lens,
    output logic [LEN_W-1:0] sol_len
);
    localparam logic [LEN_W-1:0] SYNC_OVH  = LEN_W'(10);
    localparam logic [LEN_W-1:0] BACK_OVH  = LEN_W'(14);
    localparam logic [LEN_W-1:0] FRONT_OVH = LEN_W'(8);
    localparam logic [LEN_W-1:0] FILL_LEN  = LEN_W'(15);
    localparam logic [PX_W-1:0]  SOL_PX    = PX_W'(8);

    logic [LEN_W-1:0] sync_b, back_b, act_b, front_b, bp_sum;

    always_comb begin
        sync_b  = px_to_bytes(hsync_px, fmt);
        back_b  = px_to_bytes(hback_px, fmt);
        act_b   = px_to_bytes(hact_px, fmt);
        front_b = px_to_bytes(hfront_px, fmt);
        sol_len = px_to_bytes(SOL_PX, fmt);
        bp_sum  = (mode == MODE_VID_EVT) ? (back_b + sync_b) : back_b;
        lens    = '0;
        if (mode == MODE_CMD) begin
            lens[3] = act_b + LEN_W'(1);
            lens[5] = act_b + LEN_W'(1);
        end else begin
            lens[1] = sat_sub(sync_b, SYNC_OVH);
            lens[2] = sat_sub(bp_sum, BACK_OVH);
            lens[3] = act_b;
            lens[4] = sat_sub(front_b, FRONT_OVH);
            lens[6] = FILL_LEN;
            lens[7] = FILL_LEN;
        end
    end

endmodule

// File: rtl/dsi_slot_decode.sv
module dsi_slot_decode
    import dsi_seq_pkg::*;
(
    input  logic [WORD_W-1:0]        lo_word,
    input  logic [WORD_W-1:0]        hi_word,
    output slot_t [SLOTS-1:0]        slots,
    output logic  [SLOTS-1:0]        en_mask
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        localparam int K    = s % SLOTS_PER_W;
        localparam int BASE = K * SLOT_STRIDE;
        logic [WORD_W-1:0] w;
        assign w              = (s < SLOTS_PER_W) ? lo_word : hi_word;
        assign slots[s].sel   = w[BASE +: SEL_W];
        assign slots[s].dt    = w[BASE + DT_LSB +: DT_W];
        assign slots[s].en    = w[BASE + EN_LSB];
        assign en_mask[s]     = w[BASE + EN_LSB];
    end

endmodule

// File: rtl/dsi_line_sequencer.sv
module dsi_line_sequencer
    import dsi_seq_pkg::*;
#(
    parameter int WORDS = TBL_WORDS,
    localparam int AW   = $clog2(WORDS),
    localparam int PW   = $clog2(WORDS / 2 + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic [1:0]        pix_fmt,
    input  logic [1:0]        seq_mode,
    input  logic [PX_W-1:0]   hsync_px,
    input  logic [PX_W-1:0]   hback_px,
    input  logic [PX_W-1:0]   hact_px,
    input  logic [PX_W-1:0]   hfront_px,
    input  logic              line_start,
    input  logic [PW-1:0]     line_type,
    input  logic              first_line,
    input  logic              pkt_ready,
    output logic              pkt_valid,
    output logic [DT_W-1:0]   pkt_dt,
    output logic [LEN_W-1:0]  pkt_len,
    output logic [7:0]        pkt_dcs,
    output logic              line_done,
    output logic              lp_req,
    output logic              line_busy
);
    logic [WORD_W-1:0] tbl_lo, tbl_hi;
    len_tbl_t          lens_now;
    logic [LEN_W-1:0]  sol_now;

    seq_state_e        state;
    logic [WORD_W-1:0] lo_q, hi_q;
    len_tbl_t          lens_q;
    logic [LEN_W-1:0]  sol_cnt;
    logic [IDX_W-1:0]  cur;
    logic [7:0]        dcs_q;
    logic              lp_q;

    slot_t [SLOTS-1:0] slots;
    logic  [SLOTS-1:0] en_mask;
    logic  [IDX_W:0]   first_hit, next_hit;
    logic              start_ok;

    dsi_seq_table #(.WORDS(WORDS), .DATA_W(WORD_W)) table_i (
        .clk     (clk),
        .rst     (rst),
        .we      (tbl_we),
        .waddr   (tbl_addr),
        .wdata   (tbl_wdata),
        .pair    (line_type),
        .lo_word (tbl_lo),
        .hi_word (tbl_hi)
    );

    dsi_len_calc len_i (
        .fmt       (pix_fmt_e'(pix_fmt)),
        .mode      (seq_mode_e'(seq_mode)),
        .hsync_px  (hsync_px),
        .hback_px  (hback_px),
        .hact_px   (hact_px),
        .hfront_px (hfront_px),
        .lens      (lens_now),
        .sol_len   (sol_now)
    );

    dsi_slot_decode dec_i (
        .lo_word (lo_q),
        .hi_word (hi_q),
        .slots   (slots),
        .en_mask (en_mask)
    );

    assign start_ok  = line_start && (state == ST_IDLE) && (int'(line_type) < WORDS / 2);
    assign first_hit = find_slot(en_mask, '0);
    assign next_hit  = find_slot(en_mask, cur + IDX_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lo_q    <= '0;
            hi_q    <= '0;
            lens_q  <= '0;
            sol_cnt <= '0;
            cur     <= '0;
            dcs_q   <= '0;
            lp_q    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        state   <= ST_SOL;
                        lo_q    <= tbl_lo;
                        hi_q    <= tbl_hi;
                        lens_q  <= lens_now;
                        sol_cnt <= sol_now - LEN_W'(1);
                        lp_q    <= tbl_lo[LP_BIT];
                        if (seq_mode_e'(seq_mode) == MODE_CMD)
                            dcs_q <= first_line ? DCS_MEM_START : DCS_MEM_CONT;
                        else
                            dcs_q <= 8'h00;
                    end
                end
                ST_SOL: begin
                    if (sol_cnt == '0) begin
                        if (first_hit[IDX_W]) begin
                            state <= ST_EMIT;
                            cur   <= first_hit[IDX_W-1:0];
                        end else begin
                            state <= ST_DONE;
                        end
                    end else begin
                        sol_cnt <= sol_cnt - LEN_W'(1);
                    end
                end
                ST_EMIT: begin
                    if (pkt_ready) begin
                        if (next_hit[IDX_W]) cur <= next_hit[IDX_W-1:0];
                        else                 state <= ST_DONE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign pkt_valid = (state == ST_EMIT);
    assign pkt_dt    = slots[cur].dt;
    assign pkt_len   = lens_q[slots[cur].sel];
    assign pkt_dcs   = dcs_q;
    assign line_done = (state == ST_DONE);
    assign lp_req    = line_done && lp_q;
    assign line_busy = (state != ST_IDLE);

    // R7: a stalled packet keeps its descriptor
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_dt) && $stable(pkt_len));

    // R8: end-of-line strobe lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        line_done |=> !line_done);

    // R8: low-power request only accompanies end of line
    p_lp_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        lp_req |-> line_done);

    // R8: no packet offered in the end-of-line cycle
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(pkt_valid && line_done));

    // R2: a new line never presents a packet before its delay
    p_sol_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(line_busy) |-> !pkt_valid);

endmodule

// File: tb/dsi_line_sequencer_tb_top.sv
module dsi_line_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_we = 1'b0;
    logic [3:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic [1:0]  pix_fmt = '0;
    logic [1:0]  seq_mode = 2'd2;
    logic [15:0] hsync_px = 16'd10;
    logic [15:0] hback_px = 16'd20;
    logic [15:0] hact_px = 16'd100;
    logic [15:0] hfront_px = 16'd12;
    logic        line_start = 1'b0;
    logic [2:0]  line_type = '0;
    logic        first_line = 1'b0;
    logic        pkt_ready = 1'b1;
    logic        pkt_valid;
    logic [5:0]  pkt_dt;
    logic [15:0] pkt_len;
    logic [7:0]  pkt_dcs;
    logic        line_done;
    logic        lp_req;
    logic        line_busy;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int          n_pkt, first_lat, done_k, done_cnt, stab_bad;
    bit          lp_seen;
    logic [5:0]  got_dt  [8];
    logic [15:0] got_len [8];
    logic [7:0]  got_dcs [8];

    always #4 clk = ~clk;

    dsi_line_sequencer dut_i (
        .clk(clk), .rst(rst), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .pix_fmt(pix_fmt), .seq_mode(seq_mode), .hsync_px(hsync_px), .hback_px(hback_px),
        .hact_px(hact_px), .hfront_px(hfront_px), .line_start(line_start),
        .line_type(line_type), .first_line(first_line), .pkt_ready(pkt_ready),
        .pkt_valid(pkt_valid), .pkt_dt(pkt_dt), .pkt_len(pkt_len), .pkt_dcs(pkt_dcs),
        .line_done(line_done), .lp_req(lp_req), .line_busy(line_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slotw(input int k, input bit en, input int dt, input int sel);
        return (32'(en) << (9 + 10*k)) | (32'(dt & 63) << (3 + 10*k)) | (32'(sel & 7) << (10*k));
    endfunction

    task automatic write_word(input int addr, input logic [31:0] data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 4'(addr); tbl_wdata = data;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic run_line(input int lt, input bit first, input bit stall, input int restrike,
                            input bit with_wr, input int waddr, input logic [31:0] wdata);
        bit prev_stall = 0;
        logic [5:0]  pdt = '0;
        logic [15:0] plen = '0;
        n_pkt = 0; first_lat = -1; done_k = -1; done_cnt = 0; stab_bad = 0; lp_seen = 0;
        @(negedge clk);
        line_type = 3'(lt); first_line = first; line_start = 1'b1;
        if (with_wr) begin tbl_we = 1'b1; tbl_addr = 4'(waddr); tbl_wdata = wdata; end
        @(negedge clk);
        line_start = 1'b0; tbl_we = 1'b0;
        for (int k = 1; k < 600; k++) begin
            line_start = (k == restrike);
            pkt_ready  = stall ? ((k % 3) != 0) : 1'b1;
            if (pkt_valid) begin
                if (first_lat < 0) first_lat = k - 1;
                if (prev_stall && (pkt_dt != pdt || pkt_len != plen)) stab_bad++;
                if (pkt_ready && n_pkt < 8) begin
                    got_dt[n_pkt] = pkt_dt; got_len[n_pkt] = pkt_len; got_dcs[n_pkt] = pkt_dcs;
                    n_pkt++;
                end
                prev_stall = !pkt_ready; pdt = pkt_dt; plen = pkt_len;
            end else prev_stall = 0;
            if (line_done) begin
                done_cnt++; lp_seen = lp_req; done_k = k;
                break;
            end
            @(negedge clk);
        end
        line_start = 1'b0; pkt_ready = 1'b1;
    endtask

    task automatic expect_pkt(input int i, input int dt, input int len, input string req);
        check(got_dt[i] == 6'(dt), req, int'(got_dt[i]), dt);
        check(got_len[i] == 16'(len), req, int'(got_len[i]), len);
    endtask

    task automatic program_pulse_pair3();
        write_word(6, slotw(0,1,6'h21,0) | slotw(1,1,6'h19,1) | slotw(2,1,6'h31,0));
        write_word(7, slotw(0,1,6'h19,2) | slotw(1,1,6'h3E,3) | slotw(2,1,6'h19,4));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!pkt_valid && !line_done && !lp_req && !line_busy, "R1 reset outputs",
              int'({pkt_valid, line_done, lp_req, line_busy}), 0);
    endtask

    task automatic t_video_pulse();
        pix_fmt = 2'd0; seq_mode = 2'd2;
        hsync_px = 10; hback_px = 20; hact_px = 100; hfront_px = 12;
        program_pulse_pair3();
        run_line(3, 0, 0, -1, 0, 0, 0);
        check(first_lat == 24, "R2 delay fmt0", first_lat, 24);
        check(n_pkt == 6, "R3 packet count", n_pkt, 6);
        expect_pkt(0, 6'h21, 0,   "R3 slot0");
        expect_pkt(1, 6'h19, 20,  "R4 sync len");
        expect_pkt(2, 6'h31, 0,   "R3 slot2");
        expect_pkt(3, 6'h19, 46,  "R4 back porch");
        expect_pkt(4, 6'h3E, 300, "R4 active");
        expect_pkt(5, 6'h19, 28,  "R4 front porch");
        check(got_dcs[0] == 8'h00, "R5 video opcode", int'(got_dcs[0]), 0);
        check(done_cnt == 1 && !lp_seen, "R8 done no lp", int'(lp_seen), 0);
    endtask

    task automatic t_events_skip();
        pix_fmt = 2'd2; seq_mode = 2'd1;
        write_word(0, slotw(0,1,6'h01,0) | slotw(1,0,6'h2A,3) | slotw(2,1,6'h08,7) | (32'd1 << 30));
        write_word(1, slotw(1,1,6'h19,2));
        run_line(0, 0, 0, -1, 0, 0, 0);
        check(first_lat == 16, "R2 delay fmt2", first_lat, 16);
        check(n_pkt == 3, "R3 skip disabled", n_pkt, 3);
        expect_pkt(0, 6'h01, 0,  "R3 skip order");
        expect_pkt(1, 6'h08, 15, "R4 fill entry");
        expect_pkt(2, 6'h19, 46, "R5 events back porch");
        check(lp_seen, "R8 lp request", int'(lp_seen), 1);
    endtask

    task automatic t_loose_sat();
        pix_fmt = 2'd3; seq_mode = 2'd2;
        hact_px = 101; hfront_px = 2;
        write_word(10, slotw(0,1,6'h3E,3) | slotw(2,1,6'h19,4));
        write_word(11, slotw(0,1,6'h21,1));
        run_line(5, 0, 0, -1, 0, 0, 0);
        check(first_lat == 18, "R2 delay fmt3", first_lat, 18);
        check(n_pkt == 3, "R3 count fmt3", n_pkt, 3);
        expect_pkt(0, 6'h3E, 227, "R4 loose active");
        expect_pkt(1, 6'h19, 0,   "R11 saturate");
        expect_pkt(2, 6'h21, 12,  "R4 loose sync");
    endtask

    task automatic t_command();
        pix_fmt = 2'd0; seq_mode = 2'd0; hact_px = 100;
        write_word(4, slotw(0,1,6'h39,3) | slotw(1,1,6'h39,5) | slotw(2,1,6'h05,1) | (32'd1 << 30));
        write_word(5, 32'd0);
        run_line(2, 1, 0, -1, 0, 0, 0);
        check(n_pkt == 3, "R6 cmd count", n_pkt, 3);
        expect_pkt(0, 6'h39, 301, "R6 cmd entry3");
        expect_pkt(1, 6'h39, 301, "R6 cmd entry5");
        expect_pkt(2, 6'h05, 0,   "R6 cmd other");
        check(got_dcs[0] == 8'h2C, "R6 start opcode", int'(got_dcs[0]), 'h2C);
        run_line(2, 0, 0, -1, 0, 0, 0);
        check(got_dcs[0] == 8'h3C, "R6 continue opcode", int'(got_dcs[0]), 'h3C);
    endtask

    task automatic t_stall();
        pix_fmt = 2'd0; seq_mode = 2'd2; hact_px = 100; hfront_px = 12;
        run_line(3, 0, 1, -1, 0, 0, 0);
        check(stab_bad == 0, "R7 hold under stall", stab_bad, 0);
        check(n_pkt == 6, "R7 count under stall", n_pkt, 6);
        expect_pkt(4, 6'h3E, 300, "R7 order under stall");
        check(done_cnt == 1, "R8 done under stall", done_cnt, 1);
    endtask

    task automatic t_ignore();
        int seen = 0;
        run_line(3, 0, 0, 5, 0, 0, 0);
        check(n_pkt == 6, "R9 restrike count", n_pkt, 6);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (line_busy || pkt_valid || line_done) seen++;
        end
        check(seen == 0, "R9 restrike ignored", seen, 0);
        @(negedge clk);
        line_type = 3'd6; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            if (line_busy || pkt_valid) seen++;
            @(negedge clk);
        end
        check(seen == 0, "R9 bad line type", seen, 0);
    endtask

    task automatic t_snapshot();
        pix_fmt = 2'd0; seq_mode = 2'd2;
        write_word(0, slotw(0,1,6'h01,0));
        write_word(1, 32'd0);
        run_line(0, 0, 0, -1, 1, 0, slotw(0,1,6'h11,3) | slotw(1,1,6'h12,0));
        check(n_pkt == 1, "R10 old pair count", n_pkt, 1);
        check(got_dt[0] == 6'h01, "R10 old pair dt", int'(got_dt[0]), 1);
        run_line(0, 0, 0, -1, 0, 0, 0);
        check(n_pkt == 2, "R10 new pair count", n_pkt, 2);
        expect_pkt(0, 6'h11, 300, "R10 new pair");
    endtask

    task automatic t_empty();
        pix_fmt = 2'd1; seq_mode = 2'd2;
        write_word(8, 32'd1 << 30);
        write_word(9, 32'd0);
        run_line(4, 0, 0, -1, 0, 0, 0);
        check(n_pkt == 0, "R2 empty no packets", n_pkt, 0);
        check(done_k - 1 == 24, "R2 empty done time", done_k - 1, 24);
        check(lp_seen, "R8 empty lp", int'(lp_seen), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_video_pulse();
        t_events_skip();
        t_loose_sat();
        t_command();
        t_stall();
        t_ignore();
        t_snapshot();
        t_empty();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule